// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This block moves one or more data blocks from a byte stream to an SD or MMC card running in SPI mode, once the host has already issued a write command and the card has accepted it. It runs byte by byte through an 8-bit SPI master. For each exchange it raises a one-cycle request with the byte to send. The master answers with a one-cycle acknowledge that carries the byte it received.

For every block, the engine first sends a filler byte and a start token. It then sends the payload bytes, which it pulls through a valid/ready handshake, followed by a CRC16 that it accumulates as the bytes go out. Next it searches a bounded number of reads for the card's data response token. An accepted block is followed by a busy poll until the card releases the line. After the final block of a multi-block write, the engine sends a stop token and runs one more busy poll. Each transfer ends with a single-cycle completion pulse that carries exactly one status flag.

Top module: `sdspi_blk_writer`

## Requirements
- R1: After reset the engine is idle: `active`, `spi_req`, `in_ready`, `done` and all status flags are low, and no byte exchange is started until `start`.
- R2: Each block begins with the exchange of byte 0xFF and then the start token: 0xFE when `multi` is low, 0xFC when `multi` is high.
- R3: Exactly `blk_len` payload bytes per block are taken through the handshake (a byte moves when `in_valid` and `in_ready` are both high) and are sent in arrival order. `in_ready` is high only while no exchange is outstanding.
- R4: After the payload, two CRC bytes are sent, high byte first. The CRC is CRC16 with polynomial 0x1021, initial value 0x0000, and data bits taken most significant first, computed over that block's payload only.
- R5: After the CRC, the engine reads at most 8 bytes while sending 0xFF. The first byte b with (b & 0x11) == 0x01 is the response token, and no further response byte is read after it.
- R6: If the token's low five bits differ from 0x05, or no token arrives within 8 reads, the transfer ends with `crc_err`. No further byte is exchanged and no stop token is sent.
- R7: After an accepted token, the engine polls by sending 0xFF. The first polled byte is ignored whatever its value, and any later 0xFF ends the poll. If BUSY_LIMIT polls pass without that, the transfer ends with `timeout_err`, and a multi-block write then sends no stop token.
- R8: When every block has been accepted, a single-block write ends with `ok`. A multi-block write first sends 0xFF and 0xFD and runs the same busy poll, then ends with `ok`.
- R9: `done` is high for one cycle at the end of a transfer, together with exactly one of `ok`, `crc_err` and `timeout_err`. The status flags are never high without `done`, and at most one exchange is outstanding at any time.
- R10: A busy poll after the stop token that reaches BUSY_LIMIT ends the transfer with `timeout_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| multi | input | 1 | Multi-block write when high |
| blk_count | input | CNT_W | Number of blocks to write |
| blk_len | input | SZ_W | Bytes per block (at least 1) |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Engine accepts a payload byte |
| spi_req | output | 1 | One-cycle request for a byte exchange |
| spi_tx | output | 8 | Byte to send with the request |
| spi_ack | input | 1 | Exchange finished |
| spi_rx | input | 8 | Byte received, valid with `spi_ack` |
| active | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one cycle) |
| ok | output | 1 | All blocks written |
| crc_err | output | 1 | Block rejected or no response token |
| timeout_err | output | 1 | Busy poll limit reached |

## Verification
The bench builds the engine with BUSY_LIMIT set to 20 and drives 4-byte blocks, so every timeout path finishes in a few hundred cycles. The default block length and poll limit stay in place for elaboration. With these values a bench can reach every branch: the eighth and last response read, a busy poll that expires while a block is being written, and one that expires after the stop token. It can also compare every exchanged byte against a stream it builds itself.

// File: rtl/sdspi_blk_writer.sv
module sdspi_blk_writer #(
  parameter int MAX_BLK_BYTES = 512,
  parameter int CNT_W         = 16,
  parameter int BUSY_LIMIT    = 3000000,
  parameter int RESP_TRIES    = 8,
  localparam int SZ_W   = $clog2(MAX_BLK_BYTES + 1),
  localparam int POLL_W = $clog2(BUSY_LIMIT + 1),
  localparam int TRY_W  = $clog2(RESP_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [SZ_W-1:0]  blk_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx,
  output logic             active,
  output logic             done,
  output logic             ok,
  output logic             crc_err,
  output logic             timeout_err
);

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_TOK, S_DATA, S_CRCH, S_CRCL,
    S_RESP, S_BUSY, S_SFILL, S_STOK, S_SBUSY
  } st_t;

  st_t              st;
  logic             pend;
  logic             multi_q;
  logic [CNT_W-1:0] left;
  logic [SZ_W-1:0]  len_q;
  logic [SZ_W-1:0]  nbyte;
  logic [TRY_W-1:0] tries;
  logic [POLL_W-1:0] poll;
  logic [15:0]      crc_q;
  logic [7:0]       ctl_byte;
  logic             issue, take, got;
  logic             poll_free, poll_last;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  always_comb begin
    case (st)
      S_TOK:   ctl_byte = multi_q ? 8'hFC : 8'hFE;
      S_CRCH:  ctl_byte = crc_q[15:8];
      S_CRCL:  ctl_byte = crc_q[7:0];
      S_STOK:  ctl_byte = 8'hFD;
      default: ctl_byte = 8'hFF;
    endcase
  end

  assign active    = (st != S_IDLE);
  assign in_ready  = (st == S_DATA) && !pend;
  assign take      = in_valid && in_ready;
  assign issue     = active && (st != S_DATA) && !pend;
  assign got       = pend && spi_ack;
  assign poll_free = (poll != '0) && (spi_rx == 8'hFF);
  assign poll_last = (poll == POLL_W'(BUSY_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pend        <= 1'b0;
      multi_q     <= 1'b0;
      left        <= '0;
      len_q       <= '0;
      nbyte       <= '0;
      tries       <= '0;
      poll        <= '0;
      crc_q       <= '0;
      spi_req     <= 1'b0;
      spi_tx      <= 8'hFF;
      done        <= 1'b0;
      ok          <= 1'b0;
      crc_err     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      spi_req     <= 1'b0;
      done        <= 1'b0;
      ok          <= 1'b0;
      crc_err     <= 1'b0;
      timeout_err <= 1'b0;

      if (issue) begin
        spi_req <= 1'b1;
        spi_tx  <= ctl_byte;
        pend    <= 1'b1;
      end
      if (take) begin
        spi_req <= 1'b1;
        spi_tx  <= in_data;
        pend    <= 1'b1;
        crc_q   <= crc_step(crc_q, in_data);
      end
      if (got) pend <= 1'b0;

      case (st)
        S_IDLE: if (start) begin
          multi_q <= multi;
          len_q   <= blk_len;
          left    <= blk_count;
          if (blk_count != '0) st <= S_FILL;
          else if (multi)      st <= S_SFILL;
          else begin
            done <= 1'b1;
            ok   <= 1'b1;
          end
        end
        S_FILL: if (got) begin
          crc_q <= '0;
          st    <= S_TOK;
        end
        S_TOK: if (got) begin
          nbyte <= '0;
          st    <= S_DATA;
        end
        S_DATA: if (got) begin
          if (nbyte == len_q - SZ_W'(1)) st <= S_CRCH;
          else nbyte <= nbyte + SZ_W'(1);
        end
        S_CRCH: if (got) st <= S_CRCL;
        S_CRCL: if (got) begin
          tries <= '0;
          st    <= S_RESP;
        end
        S_RESP: if (got) begin
          if ((spi_rx & 8'h11) == 8'h01) begin
            if (spi_rx[4:0] == 5'h05) begin
              poll <= '0;
              st   <= S_BUSY;
            end else begin
              st      <= S_IDLE;
              done    <= 1'b1;
              crc_err <= 1'b1;
            end
          end else if (tries == TRY_W'(RESP_TRIES - 1)) begin
            st      <= S_IDLE;
            done    <= 1'b1;
            crc_err <= 1'b1;
          end else begin
            tries <= tries + TRY_W'(1);
          end
        end
        S_BUSY: if (got) begin
          if (poll_free) begin
            if (left == CNT_W'(1)) begin
              if (multi_q) st <= S_SFILL;
              else begin
                st   <= S_IDLE;
                done <= 1'b1;
                ok   <= 1'b1;
              end
            end else begin
              left <= left - CNT_W'(1);
              st   <= S_FILL;
            end
          end else if (poll_last) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b1;
          end else begin
            poll <= poll + POLL_W'(1);
          end
        end
        S_SFILL: if (got) st <= S_STOK;
        S_STOK: if (got) begin
          poll <= '0;
          st   <= S_SBUSY;
        end
        S_SBUSY: if (got) begin
          if (poll_free) begin
            st   <= S_IDLE;
            done <= 1'b1;
            ok   <= 1'b1;
          end else if (poll_last) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            timeout_err <= 1'b1;
          end else begin
            poll <= poll + POLL_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdspi_blk_writer_chk.sv
module sdspi_blk_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic spi_req,
  input logic spi_ack,
  input logic active,
  input logic done,
  input logic ok,
  input logic crc_err,
  input logic timeout_err
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)       outstanding <= 1'b0;
    else if (spi_req) outstanding <= 1'b1;
    else if (spi_ack) outstanding <= 1'b0;
  end

  a_r9_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, crc_err, timeout_err}) == 1));

  a_r9_status_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(ok || crc_err || timeout_err));

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> !outstanding);

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |=> !spi_req);

  a_r3_take_sends: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> spi_req);

  a_r3_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (active && !outstanding));

endmodule

bind sdspi_blk_writer sdspi_blk_writer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .spi_req(spi_req), .spi_ack(spi_ack), .active(active), .done(done),
  .ok(ok), .crc_err(crc_err), .timeout_err(timeout_err)
);

// File: tb/sdspi_blk_writer_tb.sv
module sdspi_blk_writer_tb_top;
  localparam int CLK_NS = 10;
  localparam int N      = 4;
  localparam int LIMIT  = 20;
  localparam int CNT_W  = 16;
  localparam int MAXB   = 512;
  localparam int SZ_W   = $clog2(MAXB + 1);
  localparam int DEPTH  = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic multi = 1'b0;
  logic [CNT_W-1:0] blk_count = '0;
  logic [SZ_W-1:0]  blk_len = SZ_W'(N);
  logic [7:0] in_data;
  logic in_valid;
  logic in_ready;
  logic spi_req;
  logic [7:0] spi_tx;
  logic spi_ack;
  logic [7:0] spi_rx;
  logic active, done, ok, crc_err, timeout_err;

  int ncmp = 0;
  int nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  sdspi_blk_writer #(.MAX_BLK_BYTES(MAXB), .CNT_W(CNT_W), .BUSY_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
    .blk_count(blk_count), .blk_len(blk_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
    .active(active), .done(done), .ok(ok), .crc_err(crc_err), .timeout_err(timeout_err)
  );

  logic [7:0] script [DEPTH];
  logic [7:0] txlog  [DEPTH];
  logic [7:0] expv   [DEPTH];
  int ntx = 0;
  int lat = 0;
  int pidx = 0;
  int pb = 0;
  logic stall_en = 1'b0;
  logic vld = 1'b1;

  function automatic logic [7:0] pval(input int j);
    return 8'(j * 29 + 7) ^ 8'(j >> 2);
  endfunction

  function automatic logic [15:0] crc16(input int first, input int cnt);
    logic [15:0] c = 16'h0000;
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] d = pval(first + k);
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ d[i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  // card side of the SPI master
  always @(posedge clk) begin
    spi_ack <= 1'b0;
    if (!rst_n) begin
      ntx <= 0;
      lat <= 0;
      spi_rx <= 8'hFF;
    end else if (spi_req) begin
      if (ntx < DEPTH) txlog[ntx] <= spi_tx;
      ntx <= ntx + 1;
      lat <= 2;
    end else if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        spi_ack <= 1'b1;
        spi_rx  <= script[ntx-1];
      end
    end
  end

  // payload source
  assign in_valid = vld;
  assign in_data  = pval(pidx);
  always @(posedge clk) begin
    if (!rst_n) begin
      pidx <= 0;
      vld  <= 1'b1;
    end else begin
      if (in_valid && in_ready) pidx <= pidx + 1;
      vld <= stall_en ? ~vld : 1'b1;
    end
  end

  task automatic check(input bit cond, input string what, input int act, input int exp);
    ncmp++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic polls(inout int b, input int zeros, input bit to_out);
    int n;
    if (to_out) begin
      n = LIMIT;
      for (int i = 0; i < n; i++) script[b+i] = 8'h00;
    end else begin
      n = (zeros == 0) ? 2 : zeros + 1;
      for (int i = 0; i < n; i++) script[b+i] = (i < zeros) ? 8'h00 : 8'hFF;
    end
    for (int i = 0; i < n; i++) expv[b+i] = 8'hFF;
    b += n;
  endtask

  task automatic plan_block(inout int b, input int k, input bit mul, input int pre_ff,
                            input logic [7:0] tok, input int zeros, input bit to_out);
    logic [15:0] c;
    int reads;
    c = crc16(pb + k*N, N);
    expv[b]   = 8'hFF;
    expv[b+1] = mul ? 8'hFC : 8'hFE;
    for (int i = 0; i < N; i++) expv[b+2+i] = pval(pb + k*N + i);
    expv[b+2+N] = c[15:8];
    expv[b+3+N] = c[7:0];
    b += N + 4;
    reads = (pre_ff >= 8) ? 8 : pre_ff + 1;
    for (int i = 0; i < 8; i++) script[b+i] = 8'hFF;
    if (pre_ff <= 8) script[b+pre_ff] = tok;
    for (int i = 0; i < reads; i++) expv[b+i] = 8'hFF;
    b += reads;
    if (pre_ff < 8 && tok[4:0] == 5'h05) polls(b, zeros, to_out);
  endtask

  task automatic plan_stop(inout int b, input int zeros, input bit to_out);
    expv[b]   = 8'hFF;
    expv[b+1] = 8'hFD;
    b += 2;
    polls(b, zeros, to_out);
  endtask

  task automatic go(input int b0, input int endb, input int cnt, input bit mul,
                    input logic [2:0] exp_st, input string tag);
    int w = 0;
    int bad = 0;
    int bi = -1;
    logic [2:0] st;
    @(negedge clk);
    blk_count = CNT_W'(cnt);
    multi = mul;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    st = {ok, crc_err, timeout_err};
    repeat (12) @(negedge clk);
    check(st == exp_st, {tag, " status {ok,crc,to}"}, int'(st), int'(exp_st));
    check(ntx == endb, {tag, " exchange count"}, ntx - b0, endb - b0);
    for (int i = b0; i < endb && i < ntx; i++)
      if (txlog[i] !== expv[i]) begin
        bad++;
        if (bi < 0) bi = i;
      end
    check(bad == 0, {tag, " sent bytes"}, (bi < 0) ? 0 : int'(txlog[bi]), (bi < 0) ? 0 : int'(expv[bi]));
    check(!active && !in_ready, {tag, " R1 idle after done"}, int'({active, in_ready}), 0);
  endtask

  task automatic t_reset;
    check(!spi_req && !in_ready && !done && !active, "R1 reset outputs", int'({spi_req, in_ready, done, active}), 0);
    check(!ok && !crc_err && !timeout_err, "R1 reset status", int'({ok, crc_err, timeout_err}), 0);
    repeat (5) @(negedge clk);
    check(ntx == 0, "R1 no exchange before start", ntx, 0);
  endtask

  task automatic t_single;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b0, 0, 8'hE5, 3, 1'b0);
    go(b0, b, 1, 1'b0, 3'b100, "R2 R3 R4 R5 R7 single block");
  endtask

  task automatic t_multi;
    int b0 = ntx; int b = ntx; pb = pidx;
    stall_en = 1'b1;
    plan_block(b, 0, 1'b1, 0, 8'h05, 1, 1'b0);
    plan_block(b, 1, 1'b1, 1, 8'hE5, 4, 1'b0);
    plan_block(b, 2, 1'b1, 0, 8'h25, 0, 1'b0);
    plan_stop(b, 2, 1'b0);
    go(b0, b, 3, 1'b1, 3'b100, "R8 R3 multi with stop");
    stall_en = 1'b0;
  endtask

  task automatic t_late_token;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b0, 2, 8'h05, 0, 1'b0);
    go(b0, b, 1, 1'b0, 3'b100, "R5 R7 late token, first poll ignored");
  endtask

  task automatic t_reject;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b0, 0, 8'h0B, 0, 1'b0);
    go(b0, b, 1, 1'b0, 3'b010, "R6 rejected token");
  endtask

  task automatic t_no_token;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b0, 8, 8'h05, 0, 1'b0);
    go(b0, b, 1, 1'b0, 3'b010, "R5 R6 no token in 8 reads");
  endtask

  task automatic t_multi_reject;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b1, 0, 8'h05, 1, 1'b0);
    plan_block(b, 1, 1'b1, 0, 8'h0D, 0, 1'b0);
    go(b0, b, 3, 1'b1, 3'b010, "R6 multi rejected, no stop");
  endtask

  task automatic t_busy_timeout;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b1, 0, 8'h05, 0, 1'b1);
    go(b0, b, 2, 1'b1, 3'b001, "R7 block busy timeout");
  endtask

  task automatic t_stop_timeout;
    int b0 = ntx; int b = ntx; pb = pidx;
    plan_block(b, 0, 1'b1, 0, 8'h05, 2, 1'b0);
    plan_stop(b, 0, 1'b1);
    go(b0, b, 1, 1'b1, 3'b001, "R10 stop busy timeout");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      script[i] = 8'hFF;
      expv[i]   = 8'hFF;
    end
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_single;
    t_multi;
    t_late_token;
    t_reject;
    t_no_token;
    t_multi_reject;
    t_busy_timeout;
    t_stop_timeout;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncmp++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

endmodule